// File: doc/BRIEF.md
# Pushbutton Toggle Debouncer with Early-Warning Interrupt

This block converts a noisy, active-low pushbutton level into a clean on/off power state. Each qualified press flips the state. A press counts only after the button has been held low without a break for a fixed base window and then a programmable extra window. Two separate extra windows are provided, one for presses that switch the system on and one for presses that switch it off. All windows are counted in ticks of an external timebase strobe, normally one tick per millisecond. The raw button level passes through a two-flop synchronizer before any timing logic sees it.

On a press that would switch the system off, an active-low interrupt goes low as soon as the base window completes. This gives a processor early warning while the extra off window is still running. If the button is let go before that window ends, the interrupt returns high at once and the state stays on. If the press qualifies, the interrupt stays low until a shutdown-done strobe reports that power-down has finished. After any qualified press, the button must read high for a full base window before the next press can start.

Top module: `pbt_toggle_debounce`

## Requirements
- R1: After reset, `pwr_on` is 0, `toggle` is 0 and `irq_n` is 1. The button must then read high for BASE_TICKS ticks before the first press can begin.
- R2: A press qualifies only after the synchronized button has read low for BASE_TICKS ticks plus the extra ticks of that press. Any synchronized high reading during either window restarts the press from zero.
- R3: The extra ticks come from `on_extra` when `pwr_on` is 0 and from `off_extra` when `pwr_on` is 1. The value is sampled in the cycle the press begins. A value of 0 means the press qualifies as soon as the base window completes.
- R4: Each qualified press inverts `pwr_on` and raises `toggle` for exactly one cycle. `pwr_on` never changes at any other time.
- R5: On a press made while `pwr_on` is 1, `irq_n` goes low in the same clock edge that completes the base window.
- R6: If the synchronized button reads high during the extra window of such a press, `irq_n` returns high on the next clock edge and `pwr_on` stays 1.
- R7: After a qualified off press, `irq_n` stays low until a clock edge at which `shutdown_done` is 1.
- R8: After a qualified press, no new press begins until the synchronized button has read high for BASE_TICKS ticks without a break. A low reading in this window restarts it.
- R9: A press made while `pwr_on` is 0 never pulls `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe; one window count per cycle it is high |
| btn_n | input | 1 | Raw button level, low when pressed |
| on_extra | input | EXTRA_W | Extra ticks for a press that turns the system on |
| off_extra | input | EXTRA_W | Extra ticks for a press that turns the system off |
| shutdown_done | input | 1 | Strobe that releases the interrupt after power-down |
| pwr_on | output | 1 | Clean on/off state |
| toggle | output | 1 | One-cycle pulse on each qualified press |
| irq_n | output | 1 | Active-low early-warning interrupt for off presses |

## Verification
The hardest case to reach from the ports is an off press abandoned inside its extra window. That takes a qualified on press, a full release window, a held press that completes the base window, and a release before the extra ticks run out. Directed sequences build that path step by step with a steady tick. Long random runs of held and released levels, with sparse ticks and changing extra settings, land releases at many points inside both windows. A cycle-level model in the bench predicts every output on every cycle.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
    typedef enum logic [2:0] {
        ST_REL   = 3'd0,
        ST_READY = 3'd1,
        ST_BASE  = 3'd2,
        ST_EXTRA = 3'd3,
        ST_HELD  = 3'd4
    } pb_state_e;
endpackage

// File: rtl/pbt_sync.sv
module pbt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pbt_span_counter.sv
module pbt_span_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + 1'b1;
        last    = (cnt_inc == limit);
        cnt_d   = cnt_q;
        if (clr)      cnt_d = '0;
        else if (adv) cnt_d = last ? '0 : cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pbt_toggle_debounce.sv
module pbt_toggle_debounce
    import pbt_pkg::*;
#(
    parameter int BASE_TICKS  = 26,
    parameter int EXTRA_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               btn_n,
    input  logic [EXTRA_W-1:0] on_extra,
    input  logic [EXTRA_W-1:0] off_extra,
    input  logic               shutdown_done,
    output logic               pwr_on,
    output logic               toggle,
    output logic               irq_n
);
    localparam int BASE_W = $clog2(BASE_TICKS + 1);
    localparam int CNT_W  = (EXTRA_W > BASE_W) ? EXTRA_W : BASE_W;
    localparam logic [CNT_W-1:0] BASE_L = CNT_W'(BASE_TICKS);

    typedef struct packed {
        pb_state_e          st;
        logic [EXTRA_W-1:0] ext;
        logic               offp;
        logic               on;
        logic               pulse;
        logic               irq;
    } ctl_t;

    ctl_t r_d, r_q;
    logic btn_s;
    logic adv, clr, last, hit, valid;
    logic [CNT_W-1:0] limit;

    pbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(btn_n), .q(btn_s)
    );

    // window length depends on registered state only
    always_comb begin
        limit = (r_q.st == ST_EXTRA) ? CNT_W'(r_q.ext) : BASE_L;
    end

    pbt_span_counter #(.CNT_W(CNT_W)) u_span (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
        .limit(limit), .last(last)
    );

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        adv       = 1'b0;
        clr       = 1'b1;
        valid     = 1'b0;
        if (shutdown_done) r_d.irq = 1'b0;
        case (r_q.st)
            ST_REL: begin
                if (btn_s) begin
                    clr = 1'b0;
                    adv = tick;
                    if (tick && last) r_d.st = ST_READY;
                end
            end
            ST_READY: begin
                if (!btn_s) begin
                    r_d.st   = ST_BASE;
                    r_d.offp = r_q.on;
                    r_d.ext  = r_q.on ? off_extra : on_extra;
                end
            end
            ST_BASE: begin
                if (!btn_s) begin
                    clr = 1'b0;
                    adv = tick;
                    if (tick && last) begin
                        if (r_q.offp) r_d.irq = 1'b1;
                        if (r_q.ext == '0) valid = 1'b1;
                        else               r_d.st = ST_EXTRA;
                    end
                end else begin
                    r_d.st = ST_READY;
                end
            end
            ST_EXTRA: begin
                if (!btn_s) begin
                    clr = 1'b0;
                    adv = tick;
                    if (tick && last) valid = 1'b1;
                end else begin
                    r_d.st = ST_READY;
                    if (r_q.offp) r_d.irq = 1'b0;
                end
            end
            ST_HELD: begin
                if (btn_s) r_d.st = ST_REL;
            end
            default: r_d.st = ST_REL;
        endcase
        if (valid) begin
            r_d.on    = ~r_q.on;
            r_d.pulse = 1'b1;
            r_d.st    = ST_HELD;
        end
    end

    assign hit = adv & last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_REL;
            r_q.ext   <= '0;
            r_q.offp  <= 1'b0;
            r_q.on    <= 1'b0;
            r_q.pulse <= 1'b0;
            r_q.irq   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pwr_on = r_q.on;
    assign toggle = r_q.pulse;
    assign irq_n  = ~r_q.irq;

    // R4: a pulse always accompanies a flip of the state
    a_r4_pulse_flips: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulse |-> (r_q.on != $past(r_q.on)));
    // R4: the state moves only together with a pulse
    a_r4_no_silent_change: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.on) |-> r_q.pulse);
    // R4: the pulse lasts a single cycle
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulse |=> !r_q.pulse);
    // R9: the interrupt is raised only by a press made while on
    a_r9_irq_from_off_press: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.irq) |-> $past(r_q.on));
    // R7: once a press has qualified, only shutdown_done releases the interrupt
    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.irq && r_q.st == ST_HELD && !shutdown_done) |=> r_q.irq);
    // R2: a press window only completes while the button reads low
    a_r2_qualify_low: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (r_q.st == ST_BASE || r_q.st == ST_EXTRA)) |-> !btn_s);
endmodule

// File: tb/sim_pbt_toggle_debounce.sv
module sim_pbt_toggle_debounce;
    localparam int BASE = 26;
    localparam int EW   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic btn_n = 1'b1;
    logic [EW-1:0] on_extra = '0;
    logic [EW-1:0] off_extra = '0;
    logic shutdown_done = 1'b0;
    logic pwr_on, toggle, irq_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pbt_toggle_debounce #(.BASE_TICKS(BASE), .EXTRA_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n),
        .on_extra(on_extra), .off_extra(off_extra),
        .shutdown_done(shutdown_done),
        .pwr_on(pwr_on), .toggle(toggle), .irq_n(irq_n)
    );

    // reference model state: 0 rel, 1 ready, 2 base, 3 extra, 4 held
    int  m_st = 0;
    int  m_cnt = 0;
    int  m_ext = 0;
    bit  m_offp = 0, m_on = 0, m_pulse = 0, m_irq = 0;
    bit  m_s1 = 1, m_s2 = 1;

    task automatic model_step();
        bit b;
        bit valid;
        int nst;
        b = m_s2;
        valid = 0;
        nst = m_st;
        m_pulse = 0;
        if (shutdown_done) m_irq = 0;
        case (m_st)
            0: if (!b) m_cnt = 0;
               else if (tick) begin
                   m_cnt++;
                   if (m_cnt == BASE) begin m_cnt = 0; nst = 1; end
               end
            1: if (!b) begin
                   nst = 2; m_cnt = 0; m_offp = m_on;
                   m_ext = m_on ? int'(off_extra) : int'(on_extra);
               end
            2: if (b) begin nst = 1; m_cnt = 0; end
               else if (tick) begin
                   m_cnt++;
                   if (m_cnt == BASE) begin
                       m_cnt = 0;
                       if (m_offp) m_irq = 1;
                       if (m_ext == 0) valid = 1; else nst = 3;
                   end
               end
            3: if (b) begin nst = 1; m_cnt = 0; if (m_offp) m_irq = 0; end
               else if (tick) begin
                   m_cnt++;
                   if (m_cnt == m_ext) begin m_cnt = 0; valid = 1; end
               end
            default: if (b) begin nst = 0; m_cnt = 0; end
        endcase
        if (valid) begin m_on = !m_on; m_pulse = 1; nst = 4; end
        m_st = nst;
        m_s2 = m_s1;
        m_s1 = btn_n;
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R4 pwr_on model", pwr_on, m_on);
        chk("R4 toggle model", toggle, m_pulse);
        chk("R5 irq_n model", irq_n, !m_irq);
    endtask

    task automatic hold(input logic lvl, input int n);
        btn_n = lvl;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic sd_pulse();
        shutdown_done = 1'b1;
        step();
        shutdown_done = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset pwr_on", pwr_on, 1'b0);
        chk("R1 reset toggle", toggle, 1'b0);
        chk("R1 reset irq_n", irq_n, 1'b1);
        rst_n = 1'b1;
        tick = 1'b1;
        on_extra = 8'd3;
        off_extra = 8'd10;
        // R1: a press right after reset is ignored until the release window passes
        hold(1'b0, 40);
        chk("R1 no press before release window", pwr_on, 1'b0);
        hold(1'b1, 30);
        // on press with 3 extra ticks
        hold(1'b0, 25);
        chk("R2 not yet qualified", pwr_on, 1'b0);
        hold(1'b0, 10);
        chk("R2 on press qualified", pwr_on, 1'b1);
        chk("R9 on press no irq", irq_n, 1'b1);
        hold(1'b1, 30);
        // off press abandoned inside its extra window
        hold(1'b0, 33);
        chk("R5 irq low after base", irq_n, 1'b0);
        chk("R3 off extra still running", pwr_on, 1'b1);
        hold(1'b1, 4);
        chk("R6 irq released", irq_n, 1'b1);
        chk("R6 state kept", pwr_on, 1'b1);
        hold(1'b1, 30);
        // off press with zero extra
        off_extra = 8'd0;
        hold(1'b0, 31);
        chk("R3 zero extra qualifies", pwr_on, 1'b0);
        chk("R7 irq low after valid off", irq_n, 1'b0);
        hold(1'b1, 5);
        chk("R7 irq held until done", irq_n, 1'b1 ^ 1'b1);
        sd_pulse();
        step();
        chk("R7 irq released by done", irq_n, 1'b1);
        hold(1'b1, 30);
        // bounce restarts the window
        hold(1'b0, 20);
        hold(1'b1, 1);
        hold(1'b0, 20);
        chk("R2 bounce restarted window", pwr_on, 1'b0);
        hold(1'b0, 15);
        chk("R2 press after bounce", pwr_on, 1'b1);
        chk("R9 irq stays high", irq_n, 1'b1);
        // short release then press: release window not met
        hold(1'b1, 10);
        hold(1'b0, 40);
        chk("R8 short release blocks press", pwr_on, 1'b1);
        hold(1'b1, 30);
        hold(1'b0, 40);
        chk("R8 full release allows press", pwr_on, 1'b0);
        sd_pulse();
        hold(1'b1, 30);
        // random phase
        for (int s = 0; s < 2500; s++) begin
            int len;
            if ($urandom_range(0, 7) == 0) begin
                on_extra  = EW'($urandom_range(0, 20));
                off_extra = EW'($urandom_range(0, 20));
            end
            btn_n = $urandom_range(0, 1);
            len = (btn_n == 1'b0) ? $urandom_range(1, 70) : $urandom_range(1, 50);
            for (int i = 0; i < len; i++) begin
                tick = ($urandom_range(0, 3) != 0);
                shutdown_done = ($urandom_range(0, 99) == 0);
                step();
            end
            shutdown_done = 1'b0;
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule